// File: doc/BRIEF.md
# Deserializer Resync Handshake Controller

This block watches frame alignment on a byte-parallel receive path whose bytes already arrive byte-aligned. It drives an out-of-frame request line to an external deserializer/demux. It also owns the byte position counter within a frame and compares the framing bytes at the head of every frame. The request line is high while alignment is lost. The external device answers a request with a single-cycle frame pulse. The block then judges the first framing pattern after that pulse. A good pattern releases the request. A bad pattern produces a two-cycle low blip that re-arms the request.

A watchdog covers the case where the deserializer never answers. It counts three frame periods of waiting. If no pulse has arrived by then, it issues the same two-cycle blip. Once the block is aligned, it tolerates isolated errors. Only a run of four or five consecutive bad patterns drops alignment, and a configuration pin selects which of the two counts applies. A 2-bit field tells the block where the frame pulse sits relative to the framing bytes. This lets the block reload its frame counter correctly whatever the deserializer's latency.

Top module: `deser_resync_ctrl`

## Requirements
- R1: During a cycle with `rst_ni` low and after it, `oof_o` is 1 and `aligned_o` is 0, so the block requests synchronization out of reset.
- R2: The framing pattern is `A1_COUNT` bytes of 0xF6 followed by `A2_COUNT` bytes of 0x28 at frame positions 0 to PAT_LEN-1, where PAT_LEN = A1_COUNT+A2_COUNT. It is judged once per `FRAME_LEN` bytes, at position PAT_LEN-1. A wrong byte anywhere in it makes the check bad.
- R3: `fp_i` marks the byte at frame position PAT_LEN-1-`fp_offset_i`, with 0 meaning the last 0x28 byte and 3 meaning three bytes earlier. The position counter reloads from it. A pulse placed for a different offset than the configured one produces a bad check.
- R4: While awaiting a resync, a good first check after a frame pulse makes `oof_o` go low and `aligned_o` go high, and both stay there while checks are good.
- R5: While awaiting a resync, a bad first check after a frame pulse holds `oof_o` low for exactly 2 cycles before it returns high, and `aligned_o` stays 0.
- R6: While aligned, `oof_o` goes high after 4 consecutive bad checks when `thresh5_i` is 0, and after 5 when it is 1. Fewer leave it low.
- R7: A good check while aligned clears the run of bad checks.
- R8: With `oof_o` high and no frame pulse for 3*FRAME_LEN cycles, `oof_o` goes low for 2 cycles and then high. The count starts with the first cycle of the high level, and the first cycle after reset counts as that cycle.
- R9: The three-frame watchdog restarts from zero at every re-assertion of `oof_o`. Between two blips with no pulse, `oof_o` stays high for exactly 3*FRAME_LEN cycles.
- R10: Framing checks made while no frame pulse has been received have no effect on `oof_o` or `aligned_o`.
- R11: `aligned_o` is 1 only while the block is in frame, and never while `oof_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rx_byte_i | input | 8 | Received byte, already byte-aligned |
| fp_i | input | 1 | Single-cycle frame pulse from the deserializer |
| thresh5_i | input | 1 | Bad-pattern run length: 0 selects 4, 1 selects 5 |
| fp_offset_i | input | 2 | Position of the frame pulse before the last framing byte |
| oof_o | output | 1 | Out-of-frame request to the deserializer |
| aligned_o | output | 1 | High while in frame |

## Verification
The bench builds the block with a 24-byte frame and two bytes of each sync value. With these values the three-frame watchdog expires after 72 cycles, and both watchdog runs fit in a few hundred cycles. All four pulse offsets still fall inside the four-byte pattern. With such short frames, every offset can be tried under both run-length settings, with good and with bad first patterns. The exact widths of the high and low runs of the request line can also be measured, instead of only its level at frame ends.

// File: rtl/resync_pkg.sv
// Package: shared constants and state type for the resync controller.
// Assumes: framing bytes follow the usual SONET/SDH sync values.
package resync_pkg;

    localparam logic [7:0] SYNC_HEAD_BYTE = 8'hF6;
    localparam logic [7:0] SYNC_TAIL_BYTE = 8'h28;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,  // request raised, awaiting frame pulse
        ST_VERIFY = 2'd1,  // pulse seen, awaiting first pattern check
        ST_LOCKED = 2'd2,  // in frame
        ST_PULSE  = 2'd3   // request dropped briefly before re-raising
    } sync_state_e;

endpackage

// File: rtl/frame_byte_checker.sv
// Module: keeps the byte position within a frame and judges the framing
// pattern once per frame at the last framing byte.
// Assumes: bytes arrive aligned; PAT_LEN >= 4 so every offset value lands
// inside the pattern; a frame pulse reloads the position counter.
module frame_byte_checker
    import resync_pkg::*;
#(
    parameter int FRAME_LEN = 9720,
    parameter int A1_COUNT  = 12,
    parameter int A2_COUNT  = 12
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] rx_byte_i,
    input  logic       fp_i,
    input  logic [1:0] fp_offset_i,
    output logic       chk_valid_o,
    output logic       chk_good_o
);

    localparam int PAT_LEN = A1_COUNT + A2_COUNT;
    localparam int POS_W   = $clog2(FRAME_LEN);
    localparam int HIST_W  = (PAT_LEN - 1) * 8;
    localparam logic [POS_W-1:0] CHECK_POS = POS_W'(PAT_LEN - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0]     pos_q;
    logic [POS_W-1:0]     cur_pos;
    logic [HIST_W-1:0]    hist_q;
    logic [PAT_LEN*8-1:0] window;
    logic [PAT_LEN-1:0]   match;
    logic                 chk_valid_q;
    logic                 chk_good_q;

    // Position of the current byte: a frame pulse overrides the counter.
    always_comb begin
        if (fp_i) begin
            cur_pos = CHECK_POS - POS_W'(fp_offset_i);
        end else begin
            cur_pos = pos_q;
        end
    end

    // Frame position counter, wrapping at the frame length.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else if (cur_pos == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= cur_pos + 1'b1;
        end
    end

    // History of the previous PAT_LEN-1 bytes, oldest in the top byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-9:0], rx_byte_i};
        end
    end

    assign window = {hist_q, rx_byte_i};

    // One comparator per pattern byte; byte i counts from the oldest.
    for (genvar i = 0; i < PAT_LEN; i++) begin : g_cmp
        localparam logic [7:0] EXP_BYTE =
            (i < A1_COUNT) ? SYNC_HEAD_BYTE : SYNC_TAIL_BYTE;
        assign match[i] = (window[(PAT_LEN - i) * 8 - 1 -: 8] == EXP_BYTE);
    end

    // Register the verdict taken at the last framing byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chk_valid_q <= 1'b0;
            chk_good_q  <= 1'b0;
        end else begin
            chk_valid_q <= (cur_pos == CHECK_POS);
            chk_good_q  <= &match;
        end
    end

    assign chk_valid_o = chk_valid_q;
    assign chk_good_o  = chk_good_q;

endmodule

// File: rtl/bad_run_counter.sv
// Module: counts consecutive bad pattern checks while in frame and flags
// the check that completes the selected run length.
// Assumes: the counter is held clear whenever the block is not in frame.
module bad_run_counter #(
    parameter int LOW_LIMIT  = 4,
    parameter int HIGH_LIMIT = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic locked_i,
    input  logic chk_valid_i,
    input  logic chk_good_i,
    input  logic thresh5_i,
    output logic limit_o
);

    localparam int CNT_W = $clog2(HIGH_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(LOW_LIMIT);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(HIGH_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] limit_sel;

    assign cnt_inc   = cnt_q + 1'b1;
    assign limit_sel = thresh5_i ? LIM_HI : LIM_LO;

    // Run counter: cleared out of frame and by any good check.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !locked_i) begin
            cnt_q <= '0;
        end else if (chk_valid_i) begin
            cnt_q <= chk_good_i ? '0 : cnt_inc;
        end
    end

    // The bad check that reaches the selected count raises the flag.
    always_comb begin
        limit_o = locked_i && chk_valid_i && !chk_good_i
                  && (cnt_inc == limit_sel);
    end

endmodule

// File: rtl/resync_watchdog.sv
// Module: counts cycles spent awaiting a frame pulse and signals when a
// whole waiting window has elapsed.
// Assumes: run_i falls whenever the wait ends or a pulse arrives.
module resync_watchdog #(
    parameter int LIMIT = 29160
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);

    localparam int W = $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    // Cycle counter: restarts on expiry or whenever waiting stops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/oof_resync_fsm.sv
// Module: handshake state machine driving the out-of-frame request.
// Assumes: chk_valid_i arrives at most once per few cycles after a pulse;
// a frame pulse is acted on only while waiting for one.
module oof_resync_fsm
    import resync_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        fp_i,
    input  logic        chk_valid_i,
    input  logic        chk_good_i,
    input  logic        bad_limit_i,
    input  logic        wd_expire_i,
    output sync_state_e state_o,
    output logic        oof_o,
    output logic        aligned_o
);

    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LEN - 1);

    sync_state_e   state_q;
    sync_state_e   state_d;
    logic [PW-1:0] pulse_cnt_q;
    logic          oof_q;
    logic          aligned_q;

    // Next-state decision for the handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_WAIT: begin
                if (fp_i) begin
                    state_d = ST_VERIFY;
                end else if (wd_expire_i) begin
                    state_d = ST_PULSE;
                end
            end
            ST_VERIFY: begin
                if (chk_valid_i) begin
                    state_d = chk_good_i ? ST_LOCKED : ST_PULSE;
                end
            end
            ST_LOCKED: begin
                if (bad_limit_i) begin
                    state_d = ST_WAIT;
                end
            end
            ST_PULSE: begin
                if (pulse_cnt_q == PULSE_LAST) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register; reset lands in the waiting state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Length of the low blip, counted only inside it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || state_q != ST_PULSE) begin
            pulse_cnt_q <= '0;
        end else begin
            pulse_cnt_q <= pulse_cnt_q + 1'b1;
        end
    end

    // Outputs registered from the next state so they leave flops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            oof_q     <= 1'b1;
            aligned_q <= 1'b0;
        end else begin
            oof_q     <= (state_d == ST_WAIT) || (state_d == ST_VERIFY);
            aligned_q <= (state_d == ST_LOCKED);
        end
    end

    assign state_o   = state_q;
    assign oof_o     = oof_q;
    assign aligned_o = aligned_q;

endmodule

// File: rtl/deser_resync_ctrl.sv
// Module: top of the deserializer resync handshake controller.
// Assumes: byte-aligned receive data, one frame pulse per resync request,
// FRAME_LEN well above the pattern length.
module deser_resync_ctrl
    import resync_pkg::*;
#(
    parameter int FRAME_LEN  = 9720,
    parameter int A1_COUNT   = 12,
    parameter int A2_COUNT   = 12,
    parameter int LOW_LIMIT  = 4,
    parameter int HIGH_LIMIT = 5,
    parameter int PULSE_LEN  = 2,
    parameter int WD_FRAMES  = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] rx_byte_i,
    input  logic       fp_i,
    input  logic       thresh5_i,
    input  logic [1:0] fp_offset_i,
    output logic       oof_o,
    output logic       aligned_o
);

    localparam int WD_LIMIT = WD_FRAMES * FRAME_LEN;

    logic        chk_valid;
    logic        chk_good;
    logic        bad_limit;
    logic        wd_expire;
    logic        wd_run;
    logic        locked;
    sync_state_e state;

    assign wd_run = (state == ST_WAIT) && !fp_i;
    assign locked = (state == ST_LOCKED);

    frame_byte_checker #(
        .FRAME_LEN (FRAME_LEN),
        .A1_COUNT  (A1_COUNT),
        .A2_COUNT  (A2_COUNT)
    ) u_check (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rx_byte_i   (rx_byte_i),
        .fp_i        (fp_i),
        .fp_offset_i (fp_offset_i),
        .chk_valid_o (chk_valid),
        .chk_good_o  (chk_good)
    );

    bad_run_counter #(
        .LOW_LIMIT  (LOW_LIMIT),
        .HIGH_LIMIT (HIGH_LIMIT)
    ) u_run (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .locked_i    (locked),
        .chk_valid_i (chk_valid),
        .chk_good_i  (chk_good),
        .thresh5_i   (thresh5_i),
        .limit_o     (bad_limit)
    );

    resync_watchdog #(
        .LIMIT (WD_LIMIT)
    ) u_wdog (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (wd_run),
        .expire_o (wd_expire)
    );

    oof_resync_fsm #(
        .PULSE_LEN (PULSE_LEN)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fp_i        (fp_i),
        .chk_valid_i (chk_valid),
        .chk_good_i  (chk_good),
        .bad_limit_i (bad_limit),
        .wd_expire_i (wd_expire),
        .state_o     (state),
        .oof_o       (oof_o),
        .aligned_o   (aligned_o)
    );

endmodule

// File: rtl/resync_ctrl_props.sv
// Module: property checker for the resync controller, bound to the top.
module resync_ctrl_props (
    input logic clk_i,
    input logic rst_ni,
    input logic oof_o,
    input logic aligned_o,
    input logic chk_valid,
    input logic chk_good
);

    logic ran_q;

    // Marks that the previous cycle was out of reset.
    always_ff @(posedge clk_i) begin
        ran_q <= rst_ni;
    end

    assert_reset_requests_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (oof_o && !aligned_o));

    assert_aligned_not_oof_R11: assert property (@(posedge clk_i)
        disable iff (!rst_ni) aligned_o |-> !oof_o);

    assert_blip_two_cycles_R5: assert property (@(posedge clk_i)
        disable iff (!rst_ni)
        ($fell(oof_o) && !aligned_o) |=> (!oof_o ##1 oof_o));

    assert_lock_after_good_R4: assert property (@(posedge clk_i)
        disable iff (!rst_ni)
        $rose(aligned_o) |-> $past(chk_valid && chk_good));

    assert_lock_holds_R6: assert property (@(posedge clk_i)
        disable iff (!rst_ni)
        (aligned_o && !(chk_valid && !chk_good)) |=> aligned_o);

    assert_unlock_needs_bad_R6: assert property (@(posedge clk_i)
        disable iff (!rst_ni)
        ($fell(aligned_o) && ran_q) |-> ($past(chk_valid && !chk_good) && oof_o));

endmodule

bind deser_resync_ctrl resync_ctrl_props u_props (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oof_o     (oof_o),
    .aligned_o (aligned_o),
    .chk_valid (chk_valid),
    .chk_good  (chk_good)
);

// File: tb/sim_deser_resync_ctrl.sv
module sim_deser_resync_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int F   = 24;
    localparam int A1N = 2;
    localparam int A2N = 2;
    localparam int PL  = A1N + A2N;

    // Row bits: [3] thresh5, [2:1] pulse offset, [0] first pattern good.
    localparam logic [3:0] VEC_TBL [6] = '{
        4'b0001, 4'b1111, 4'b0100, 4'b1011, 4'b0011, 4'b1000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       fp = 1'b0;
    logic       th5 = 1'b0;
    logic [1:0] offs = 2'd0;
    logic       oof;
    logic       aligned;

    int n_checks = 0;
    int n_fail = 0;
    int hi_run, lo_run, last_lo, hi_cnt;
    int hi_log [4];
    int row_cfg, row_off, row_good, row_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    deser_resync_ctrl #(
        .FRAME_LEN (F),
        .A1_COUNT  (A1N),
        .A2_COUNT  (A2N)
    ) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_byte_i   (rx_byte),
        .fp_i        (fp),
        .thresh5_i   (th5),
        .fp_offset_i (offs),
        .oof_o       (oof),
        .aligned_o   (aligned)
    );

    // Run-length monitor of the request line, sampled just after each edge.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; last_lo = -1; hi_cnt = 0;
        end else if (oof) begin
            if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
            hi_run++;
        end else begin
            if (hi_run > 0) begin
                if (hi_cnt < 4) begin hi_log[hi_cnt] = hi_run; hi_cnt++; end
                hi_run = 0;
            end
            lo_run++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Drive one byte now and move on to the next falling edge.
    task automatic tick(input logic [7:0] b, input logic f);
        rx_byte = b;
        fp = f;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fp = 1'b0; rx_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One frame; bad corrupts the first sync byte; pulse placed for off.
    task automatic send_frame(input bit bad, input bit with_fp, input int off);
        for (int p = 0; p < F; p++) begin
            logic [7:0] b;
            if (p < A1N) b = 8'hF6;
            else if (p < PL) b = 8'h28;
            else b = 8'h55;
            if (bad && p == 0) b = 8'h00;
            tick(b, with_fp && (p == PL - 1 - off));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        // Table walk: acquisition under each offset and threshold.
        for (int i = 0; i < 6; i++) begin
            row_cfg  = int'(VEC_TBL[i][3]);
            row_off  = int'(VEC_TBL[i][2:1]);
            row_good = int'(VEC_TBL[i][0]);
            row_n    = row_cfg ? 5 : 4;
            th5  = VEC_TBL[i][3];
            offs = VEC_TBL[i][2:1];
            do_reset();
            check("R1 oof after reset", int'(oof), 1);
            check("R1 aligned after reset", int'(aligned), 0);
            send_frame(row_good == 0, 1'b1, row_off);
            if (row_good != 0) begin
                check("R4 R3 oof low after good first pattern", int'(oof), 0);
                check("R11 aligned after good first pattern", int'(aligned), 1);
                repeat (row_n - 1) send_frame(1'b1, 1'b0, 0);
                check("R6 below bad-run threshold", int'(oof), 0);
                send_frame(1'b0, 1'b0, 0);
                repeat (row_n - 1) send_frame(1'b1, 1'b0, 0);
                check("R7 good pattern cleared run", int'(oof), 0);
                send_frame(1'b1, 1'b0, 0);
                check("R6 R2 oof after bad run", int'(oof), 1);
                check("R11 aligned dropped", int'(aligned), 0);
            end else begin
                check("R5 R2 oof back high after bad first", int'(oof), 1);
                check("R5 blip width", last_lo, 2);
                check("R5 R11 aligned stays low", int'(aligned), 0);
            end
        end

        // Watchdog: aligned good frames but no pulse, seven frames long.
        th5 = 1'b0; offs = 2'd0;
        do_reset();
        repeat (7) send_frame(1'b0, 1'b0, 0);
        check("R8 first wait length", hi_log[0], 3 * F - 1);
        check("R9 restarted wait length", hi_log[1], 3 * F);
        check("R8 watchdog blip width", last_lo, 2);
        check("R10 blips seen despite good patterns", hi_cnt, 2);
        check("R10 aligned stays low without pulse", int'(aligned), 0);

        // Offset mismatch: pulse placed for offset 2 while configured 0.
        do_reset();
        send_frame(1'b0, 1'b1, 2);
        check("R3 mismatched offset rejected", int'(oof), 1);
        check("R3 mismatched offset blip", last_lo, 2);
        offs = 2'd2;
        send_frame(1'b0, 1'b1, 2);
        check("R3 matching offset locks", int'(aligned), 1);

        // Reset while locked.
        do_reset();
        check("R1 reset from lock oof", int'(oof), 1);
        check("R1 reset from lock aligned", int'(aligned), 0);

        summary();
        $finish;
    end

endmodule